// File: doc/BRIEF.md
# Carry-Select Next-PC Adder

This combinational unit produces the address of the next sequential instruction in a fetch stage that handles variable-length instructions. The opcode byte is always present. A decoded instruction may also carry one register-specifier byte and a four-byte constant. The unit adds the resulting length to the current PC.

The timing problem is that the length is known only late, after the opcode byte has been read from instruction memory. The PC is therefore split into a narrow low field and a wide high field. As soon as the PC is stable, a wide incrementer computes the high field plus one. When the length arrives, only a short adder acts on the low field. Its carry out drives a final two-way multiplexer, which picks either the unchanged high field or the pre-incremented one. The late path is therefore one narrow add followed by one mux level.

Top module: `pcinc_carry_select`

## Requirements
- R1: With both flags low, the instruction length is 1, so next_pc_o equals pc_i + 1.
- R2: With only need_regids_i high, the length is 2.
- R3: With only need_const_i high, the length is 5; with both flags high it is 6.
- R4: Bits [2:0] of next_pc_o equal (pc_i[2:0] + length) modulo 8.
- R5: If pc_i[2:0] + length stays below 8, bits [31:3] of next_pc_o equal pc_i[31:3].
- R6: If pc_i[2:0] + length reaches 8 or more, bits [31:3] of next_pc_o equal pc_i[31:3] + 1 modulo 2^29.
- R7: For every PC value and flag combination, next_pc_o equals pc_i + length modulo 2^32. This includes PCs near 0xFFFFFFFF, where the result wraps to a small value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Current instruction address |
| need_regids_i | input | 1 | Instruction carries a register-specifier byte |
| need_const_i | input | 1 | Instruction carries a four-byte constant |
| next_pc_o | output | 32 | Address of the following instruction |

## Verification
The embedded checks assume that both decode flags are plain 0/1 levels and that the 32-bit PC input holds no unknown bits. The checks are evaluated whenever an input changes. The stimulus drives each vector completely in one step and waits before sampling, so no partially updated input is ever checked. Random PCs are mixed with directed values: every low-field value from 0 to 7, the all-ones PC, and PCs whose high field is all ones. Together these reach the carry into the high field and the wrap of the full 32-bit address.

// File: rtl/pcinc_pkg.sv
package pcinc_pkg;
  localparam int unsigned PC_W      = 32;
  localparam int unsigned LO_W      = 3;
  localparam int unsigned HI_W      = PC_W - LO_W;
  localparam int unsigned LEN_OPC   = 1;
  localparam int unsigned LEN_REG   = 1;
  localparam int unsigned LEN_CONST = 4;
  localparam int unsigned LEN_MAX   = LEN_OPC + LEN_REG + LEN_CONST;
endpackage

// File: rtl/pcinc_len_dec.sv
module pcinc_len_dec
  import pcinc_pkg::*;
#(
  parameter int unsigned LW = LO_W
) (
  input  logic          need_regids_i,
  input  logic          need_const_i,
  output logic [LW-1:0] len_o
);
  localparam logic [LW-1:0] OPC_L   = LW'(LEN_OPC);
  localparam logic [LW-1:0] REG_L   = LW'(LEN_REG);
  localparam logic [LW-1:0] CONST_L = LW'(LEN_CONST);

  always_comb begin
    len_o = OPC_L;
    if (need_regids_i) len_o = len_o + REG_L;
    if (need_const_i)  len_o = len_o + CONST_L;
  end

  // R3
  always_comb begin
    if (!$isunknown({need_regids_i, need_const_i}))
      len_range_chk: assert (len_o >= OPC_L && 32'(len_o) <= LEN_MAX)
        else $error("length out of range");
  end
endmodule

// File: rtl/pcinc_lo_add.sv
module pcinc_lo_add #(
  parameter int unsigned LW = 3
) (
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  output logic [LW-1:0] sum_o,
  output logic          cout_o
);
  logic [LW:0] c;
  assign c[0] = 1'b0;

  for (genvar i = 0; i < LW; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = c[LW];

  // R4
  always_comb begin
    if (!$isunknown({a_i, b_i}))
      lo_sum_chk: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}))
        else $error("narrow adder mismatch");
  end
endmodule

// File: rtl/pcinc_hi_inc.sv
module pcinc_hi_inc #(
  parameter int unsigned HW = 29
) (
  input  logic [HW-1:0] hi_i,
  output logic [HW-1:0] hi_inc_o
);
  logic [HW:0] c;
  assign c[0] = 1'b1;

  for (genvar i = 0; i < HW; i++) begin : g_ha
    assign hi_inc_o[i] = hi_i[i] ^ c[i];
    assign c[i+1]      = hi_i[i] & c[i];
  end

  // R6
  always_comb begin
    if (!$isunknown(hi_i))
      hi_inc_chk: assert (hi_inc_o == hi_i + HW'(1))
        else $error("wide incrementer mismatch");
  end
endmodule

// File: rtl/pcinc_carry_select.sv
module pcinc_carry_select
  import pcinc_pkg::*;
(
  input  logic [PC_W-1:0] pc_i,
  input  logic            need_regids_i,
  input  logic            need_const_i,
  output logic [PC_W-1:0] next_pc_o
);
  logic [LO_W-1:0] len;
  logic [LO_W-1:0] lo_sum;
  logic            lo_cout;
  logic [HI_W-1:0] hi_plus1;
  logic [HI_W-1:0] hi_sel;

  // early path: depends only on the PC
  pcinc_hi_inc #(.HW(HI_W)) u_hi_inc (
    .hi_i     (pc_i[PC_W-1:LO_W]),
    .hi_inc_o (hi_plus1)
  );

  pcinc_len_dec #(.LW(LO_W)) u_len (
    .need_regids_i (need_regids_i),
    .need_const_i  (need_const_i),
    .len_o         (len)
  );

  pcinc_lo_add #(.LW(LO_W)) u_lo_add (
    .a_i    (pc_i[LO_W-1:0]),
    .b_i    (len),
    .sum_o  (lo_sum),
    .cout_o (lo_cout)
  );

  assign hi_sel    = lo_cout ? hi_plus1 : pc_i[PC_W-1:LO_W];
  assign next_pc_o = {hi_sel, lo_sum};

  always_comb begin
    if (!$isunknown({pc_i, need_regids_i, need_const_i})) begin
      // R5
      hi_hold_chk: assert (lo_cout || next_pc_o[PC_W-1:LO_W] == pc_i[PC_W-1:LO_W])
        else $error("high field changed without carry");
      // R7
      full_sum_chk: assert (next_pc_o == pc_i + PC_W'(len))
        else $error("next pc mismatch");
    end
  end
endmodule

// File: tb/tb_pcinc_carry_select.sv
module tb_pcinc_carry_select;
  logic        clk = 1'b0;
  logic [31:0] pc_i;
  logic        need_regids_i, need_const_i;
  logic [31:0] next_pc_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  pcinc_carry_select dut (
    .pc_i          (pc_i),
    .need_regids_i (need_regids_i),
    .need_const_i  (need_const_i),
    .next_pc_o     (next_pc_o)
  );

  function automatic int unsigned exp_len(bit r, bit c);
    return 1 + (r ? 1 : 0) + (c ? 4 : 0);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s pc=%h r=%0b c=%0b act=%h exp=%h",
               req, pc_i, need_regids_i, need_const_i, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] pc, bit r, bit c);
    int unsigned len;
    int unsigned lo_tot;
    logic [31:0] exp;
    @(posedge clk);
    pc_i = pc; need_regids_i = r; need_const_i = c;
    @(negedge clk);
    len    = exp_len(r, c);
    lo_tot = int'(pc[2:0]) + len;
    exp    = pc + len;
    if (!r && !c)     chk("R1", next_pc_o, pc + 32'd1);
    else if (r && !c) chk("R2", next_pc_o, pc + 32'd2);
    else              chk("R3", next_pc_o, pc + (r ? 32'd6 : 32'd5));
    chk("R4", {29'd0, next_pc_o[2:0]}, 32'(lo_tot % 8));
    if (lo_tot < 8) chk("R5", {3'd0, next_pc_o[31:3]}, {3'd0, pc[31:3]});
    else            chk("R6", {3'd0, next_pc_o[31:3]}, {3'd0, pc[31:3] + 29'd1});
    chk("R7", next_pc_o, exp);
  endtask

  initial begin
    void'($urandom(32'h1badc0de));
    pc_i = '0; need_regids_i = 1'b0; need_const_i = 1'b0;
    @(negedge clk);
    chk("R1", next_pc_o, 32'd1);
    for (int lo = 0; lo < 8; lo++)
      for (int f = 0; f < 4; f++) begin
        apply({29'h0ABCDEF, 3'(lo)}, f[0], f[1]);
        apply({29'h1FFFFFFF, 3'(lo)}, f[0], f[1]);
        apply({29'h0, 3'(lo)}, f[0], f[1]);
      end
    for (int f = 0; f < 4; f++) begin
      apply(32'hFFFF_FFFF, f[0], f[1]);
      apply(32'h7FFF_FFFA, f[0], f[1]);
    end
    for (int i = 0; i < 3000; i++)
      apply($urandom, 1'($urandom), 1'($urandom));
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule